// File: doc/BRIEF.md
# Audio PCM PWM Timer

This block turns a stream of PCM audio samples into a pulse-width-modulated pin. Each sample written to it is first widened to 16 bits and then scaled by a digital volume gain. The result becomes a 16-bit level. The level is split into an upper coarse field and a lower fine field, and one of three split points is selectable. The coarse field sets the carrier period and the number of clocks the pin stays high in each period. When fine mode is on, the fine field is accumulated from period to period. Each time the accumulator overflows, one extra clock of pulse width is added, so over many periods the average width resolves the full 16-bit level.

A sample-rate divider derived from the clock frequency issues a one-cycle request at the chosen audio rate. A DMA engine or software uses that request to supply the next sample. Two compare-match strobes are available for interrupts, and each has its own enable: one at the end of every carrier period, one at the clock where the pulse ends. A written sample waits in a holding register and only reaches the comparator at a period boundary, so no carrier period ever shows a partial pulse.

Top module: `pcm_pwm_timer`

## Requirements
- R1: While `run_i` is low, `pwm_o`, `evt_o` and `req_o` stay low. The carrier counter and fine accumulator are cleared, so a restart begins a fresh period with the accumulator at zero.
- R2: `mode_i` selects the split of the 16-bit level. Value 0 gives a 10-bit coarse field and a 1024-clock period. Value 1 gives a 9-bit coarse field and a 512-clock period. Values 2 and 3 give an 8-bit coarse field and a 256-clock period. Without fine mode, the pulse width equals the coarse field, which is the level shifted right by the fine width (6, 7 or 8 bits).
- R3: When `smp_8bit_i` is high, only `smp_data_i[7:0]` is used, placed in the upper byte with a zero lower byte. Otherwise all 16 bits of `smp_data_i` are used as an unsigned sample.
- R4: On a clock with `smp_we_i` high, the held level becomes floor(sample × `gain_i` / 256), using the gain present in that cycle. A gain of zero gives a level of zero, so no pulse is produced.
- R5: With `fine_en_i` high, loaded period k after a start (k = 1, 2, ...) is wider than the coarse field by floor(k·f/2^F) − floor((k−1)·f/2^F) clocks. Here f is the fine field and F is its width. With `fine_en_i` low, no extra clocks are added.
- R6: A held level reaches the output only at a carrier period boundary. A write made in the middle of a period leaves that period's width unchanged and takes effect in the next period. The first period after `run_i` rises has zero width.
- R7: `evt_o[0]` is a one-cycle strobe on the last clock of every carrier period, and only while `irq_en_i[0]` is high.
- R8: `evt_o[1]` is a one-cycle strobe on the first low clock after a pulse, and only while `irq_en_i[1]` is high. It fires only in periods whose width is nonzero and shorter than the period.
- R9: `req_o` pulses for one clock every D clocks while running, where D = floor(`CLK_HZ` / rate). `rate_sel_i` values 0 to 5 select 8000, 16000, 22050, 32000, 44100 and 48000 Hz. Values 6 and 7 select 48000 Hz.
- R10: Each pulse starts on the first clock of a carrier period and is high for contiguous clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Enables the carrier and the rate divider |
| mode_i | input | 2 | Coarse/fine split select |
| fine_en_i | input | 1 | Enables fine-field dithering |
| rate_sel_i | input | 3 | Sample-rate select |
| gain_i | input | 8 | Volume gain applied at sample write |
| smp_we_i | input | 1 | Sample write strobe |
| smp_8bit_i | input | 1 | Sample is 8-bit in the low byte |
| smp_data_i | input | 16 | Sample data |
| irq_en_i | input | 2 | Enables for the two compare-match strobes |
| pwm_o | output | 1 | PWM output |
| evt_o | output | 2 | [0] period-end strobe, [1] pulse-end strobe |
| req_o | output | 1 | Sample request strobe |

## Verification
The bench builds the block with `CLK_HZ` = 480000. This shrinks the rate divisors to 60, 30, 21, 15, 10 and 10 clocks, so every rate, including the truncation of the 22.05 kHz and 44.1 kHz divisors and the fallback of the unused selections, can be measured directly between two requests. With these settings the longest carrier period is 1024 clocks. That makes it affordable to measure three consecutive loaded periods in every split mode, enough to see the fine carries land in the predicted periods. The same window covers mid-period sample writes and masked strobes.

// File: rtl/pcm_pwm_pkg.sv
package pcm_pwm_pkg;

  localparam int SMP_W      = 16;
  localparam int GAIN_W     = 8;
  localparam int MAX_COARSE = 10;
  localparam int MIN_COARSE = 8;
  localparam int ACC_W      = SMP_W - MIN_COARSE;

  // Widen a raw sample to 16 bits; 8-bit samples sit in the upper byte.
  function automatic logic [SMP_W-1:0] widen_sample(input logic [SMP_W-1:0] raw,
                                                     input logic narrow);
    return narrow ? {raw[7:0], 8'h00} : raw;
  endfunction

  // Volume stage: product with the gain, keep the upper 16 bits.
  function automatic logic [SMP_W-1:0] scale_level(input logic [SMP_W-1:0] smp,
                                                    input logic [GAIN_W-1:0] gain);
    logic [SMP_W+GAIN_W-1:0] prod;
    prod = smp * gain;
    return prod[SMP_W+GAIN_W-1:GAIN_W];
  endfunction

  // Last counter value of a carrier period for each split.
  function automatic logic [MAX_COARSE-1:0] period_last(input logic [1:0] split);
    case (split)
      2'd0:    return 10'h3FF;
      2'd1:    return 10'h1FF;
      default: return 10'h0FF;
    endcase
  endfunction

  function automatic logic [MAX_COARSE-1:0] coarse_field(input logic [SMP_W-1:0] lvl,
                                                          input logic [1:0] split);
    case (split)
      2'd0:    return lvl[15:6];
      2'd1:    return {1'b0, lvl[15:7]};
      default: return {2'b00, lvl[15:8]};
    endcase
  endfunction

  function automatic logic [ACC_W-1:0] fine_field(input logic [SMP_W-1:0] lvl,
                                                   input logic [1:0] split);
    case (split)
      2'd0:    return {2'b00, lvl[5:0]};
      2'd1:    return {1'b0, lvl[6:0]};
      default: return lvl[7:0];
    endcase
  endfunction

  function automatic logic [ACC_W-1:0] fine_mask(input logic [1:0] split);
    case (split)
      2'd0:    return 8'h3F;
      2'd1:    return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  // Carry out of the fine accumulator at the split's fine width.
  function automatic logic fine_carry(input logic [ACC_W:0] sum,
                                      input logic [1:0] split);
    case (split)
      2'd0:    return sum[6];
      2'd1:    return sum[7];
      default: return sum[8];
    endcase
  endfunction

  // Clocks per audio sample for a rate selection.
  function automatic int unsigned rate_divisor(input int unsigned clk_hz,
                                               input logic [2:0] sel);
    case (sel)
      3'd0:    return clk_hz / 8000;
      3'd1:    return clk_hz / 16000;
      3'd2:    return clk_hz / 22050;
      3'd3:    return clk_hz / 32000;
      3'd4:    return clk_hz / 44100;
      default: return clk_hz / 48000;
    endcase
  endfunction

endpackage

// File: rtl/pwm_rate_div.sv
module pwm_rate_div #(
  parameter int unsigned CLK_HZ = 48_000_000,
  parameter int          DIV_W  = $clog2(CLK_HZ / 8000 + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  import pcm_pwm_pkg::*;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  always_comb last = DIV_W'(rate_divisor(CLK_HZ, sel_i) - 1);

  assign tick_o = run_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_sample_hold.sv
module pwm_sample_hold
  import pcm_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              narrow_i,
  input  logic [SMP_W-1:0]  data_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [SMP_W-1:0]  level_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   level_o <= '0;
    else if (we_i) level_o <= scale_level(widen_sample(data_i, narrow_i), gain_i);
  end
endmodule

// File: rtl/pwm_carrier.sv
module pwm_carrier
  import pcm_pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [1:0]       mode_i,
  input  logic             fine_en_i,
  input  logic [SMP_W-1:0] level_i,
  output logic             pwm_o,
  output logic             period_end_o,
  output logic             duty_hit_o
);
  logic [MAX_COARSE-1:0] cnt_q;
  logic [MAX_COARSE:0]   duty_q;
  logic [ACC_W-1:0]      acc_q;
  logic [ACC_W:0]        acc_sum;
  logic                  carry;

  assign acc_sum = {1'b0, acc_q} + {1'b0, fine_field(level_i, mode_i)};
  assign carry   = fine_en_i && fine_carry(acc_sum, mode_i);

  assign period_end_o = run_i && (cnt_q >= period_last(mode_i));
  assign pwm_o        = run_i && ({1'b0, cnt_q} < duty_q);
  assign duty_hit_o   = run_i && (duty_q != '0) && ({1'b0, cnt_q} == duty_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      duty_q <= '0;
      acc_q  <= '0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      duty_q <= '0;
      acc_q  <= '0;
    end else if (period_end_o) begin
      cnt_q  <= '0;
      duty_q <= {1'b0, coarse_field(level_i, mode_i)} + (MAX_COARSE+1)'(carry);
      acc_q  <= fine_en_i ? (acc_sum[ACC_W-1:0] & fine_mask(mode_i)) : '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_pwm_timer.sv
module pcm_pwm_timer #(
  parameter int unsigned CLK_HZ = 48_000_000,
  localparam int         DIV_W  = $clog2(CLK_HZ / 8000 + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic [1:0]  mode_i,
  input  logic        fine_en_i,
  input  logic [2:0]  rate_sel_i,
  input  logic [7:0]  gain_i,
  input  logic        smp_we_i,
  input  logic        smp_8bit_i,
  input  logic [15:0] smp_data_i,
  input  logic [1:0]  irq_en_i,
  output logic        pwm_o,
  output logic [1:0]  evt_o,
  output logic        req_o
);
  import pcm_pwm_pkg::*;

  logic [SMP_W-1:0] level;
  logic             period_end;
  logic             duty_hit;

  pwm_rate_div #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .sel_i  (rate_sel_i),
    .tick_o (req_o)
  );

  pwm_sample_hold u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (smp_we_i),
    .narrow_i (smp_8bit_i),
    .data_i   (smp_data_i),
    .gain_i   (gain_i),
    .level_o  (level)
  );

  pwm_carrier u_carrier (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .mode_i       (mode_i),
    .fine_en_i    (fine_en_i),
    .level_i      (level),
    .pwm_o        (pwm_o),
    .period_end_o (period_end),
    .duty_hit_o   (duty_hit)
  );

  assign evt_o = {duty_hit & irq_en_i[1], period_end & irq_en_i[0]};
endmodule

// File: rtl/pcm_pwm_checker.sv
module pcm_pwm_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_i,
  input logic [1:0] irq_en_i,
  input logic       pwm_o,
  input logic [1:0] evt_o,
  input logic       req_o,
  input logic       period_end,
  input logic       duty_hit
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!pwm_o && evt_o == 2'b00 && !req_o));

  assert_rise_at_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_o) |-> $past(period_end));

  assert_fall_at_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && $fell(pwm_o)) |-> (duty_hit || $past(period_end)));

  assert_period_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i[0] |-> !evt_o[0]);

  assert_pulse_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i[1] |-> !evt_o[1]);

  assert_req_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
endmodule

bind pcm_pwm_timer pcm_pwm_checker u_pcm_pwm_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_i),
  .irq_en_i   (irq_en_i),
  .pwm_o      (pwm_o),
  .evt_o      (evt_o),
  .req_o      (req_o),
  .period_end (period_end),
  .duty_hit   (duty_hit)
);

// File: tb/test_pcm_pwm_timer.sv
module test_pcm_pwm_timer;
  localparam int unsigned CLK_HZ = 480000;

  typedef struct packed {
    logic [1:0]  mode;
    logic        narrow;
    logic [15:0] data;
    logic [7:0]  gain;
    logic        fine;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd2, 1'b1, 16'h0080, 8'hFF, 1'b0},
    '{2'd2, 1'b0, 16'hFFFF, 8'hFF, 1'b1},
    '{2'd0, 1'b0, 16'h1234, 8'h80, 1'b1},
    '{2'd1, 1'b0, 16'hABCD, 8'hC0, 1'b1},
    '{2'd1, 1'b1, 16'h77FF, 8'h40, 1'b0},
    '{2'd0, 1'b0, 16'hFFFF, 8'hFF, 1'b1},
    '{2'd2, 1'b0, 16'h4321, 8'h00, 1'b1},
    '{2'd3, 1'b0, 16'h6060, 8'hFF, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [1:0]  mode = 2'd2;
  logic        fine_en = 1'b0;
  logic [2:0]  rate_sel = 3'd0;
  logic [7:0]  gain = 8'h00;
  logic        smp_we = 1'b0;
  logic        smp_8bit = 1'b0;
  logic [15:0] smp_data = 16'h0000;
  logic [1:0]  irq_en = 2'b11;
  logic        pwm;
  logic [1:0]  evt;
  logic        req;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  pcm_pwm_timer #(.CLK_HZ(CLK_HZ)) i_pcm_pwm_timer (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .mode_i(mode), .fine_en_i(fine_en),
    .rate_sel_i(rate_sel), .gain_i(gain), .smp_we_i(smp_we), .smp_8bit_i(smp_8bit),
    .smp_data_i(smp_data), .irq_en_i(irq_en), .pwm_o(pwm), .evt_o(evt), .req_o(req)
  );

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  // Bench-side restatement of the level: plain integer arithmetic.
  function automatic int model_level(input vec_t v);
    int s;
    s = v.narrow ? int'(v.data[7:0]) * 256 : int'(v.data);
    return (s * int'(v.gain)) / 256;
  endfunction

  function automatic int fine_bits(input logic [1:0] m);
    return (m == 2'd0) ? 6 : (m == 2'd1) ? 7 : 8;
  endfunction

  function automatic int model_width(input vec_t v, input int k);
    int lv, fb, c, f;
    lv = model_level(v);
    fb = fine_bits(v.mode);
    c  = lv / (1 << fb);
    f  = lv % (1 << fb);
    if (!v.fine) return c;
    return c + (k * f) / (1 << fb) - ((k - 1) * f) / (1 << fb);
  endfunction

  task automatic write_sample(input vec_t v);
    @(negedge clk);
    gain = v.gain; smp_8bit = v.narrow; smp_data = v.data; smp_we = 1'b1;
    @(negedge clk);
    smp_we = 1'b0;
  endtask

  // Stop, configure, load, start; leaves the bench at counter 0 of the first loaded period.
  task automatic start_vec(input vec_t v, input logic [1:0] en);
    @(negedge clk);
    run = 1'b0; mode = v.mode; fine_en = v.fine; irq_en = en;
    write_sample(v);
    run = 1'b1;
    repeat (1 << (16 - fine_bits(v.mode))) @(negedge clk);
  endtask

  // Measure one carrier period; optionally write a new sample at clock 10.
  task automatic measure_period(input int p, input bit wr, input vec_t nv,
                                output int hi, output int e0, output int e1);
    hi = 0; e0 = 0; e1 = 0;
    for (int i = 0; i < p; i++) begin
      hi += int'(pwm);
      e0 += int'(evt[0]);
      e1 += int'(evt[1]);
      if (wr && i == 10) begin
        gain = nv.gain; smp_8bit = nv.narrow; smp_data = nv.data; smp_we = 1'b1;
      end else begin
        smp_we = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  task automatic measure_rate(input logic [2:0] sel, input int exp);
    int n;
    @(negedge clk);
    run = 1'b0; rate_sel = sel;
    @(negedge clk);
    run = 1'b1;
    n = 0;
    while (!req && n < 200) begin @(negedge clk); n++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!req && n < 200);
    check(n == exp, "R9 rate divisor", n, exp);
  endtask

  initial begin
    int hi, e0, e1, p, w, fin;
    vec_t a, b;

    // R1: reset and idle state
    repeat (3) @(negedge clk);
    check(pwm == 1'b0 && evt == 2'b00 && req == 1'b0, "R1 in reset", int'({pwm, evt, req}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(pwm == 1'b0 && evt == 2'b00 && req == 1'b0, "R1 idle", int'({pwm, evt, req}), 0);

    // Vector table: R2 split, R3 width, R4 volume, R5 fine, R7/R8 strobes
    for (int v = 0; v < 8; v++) begin
      start_vec(VECS[v], 2'b11);
      p = 1 << (16 - fine_bits(VECS[v].mode));
      e0 = 0;
      for (int k = 1; k <= 3; k++) begin
        int h, a0, a1;
        measure_period(p, 1'b0, VECS[v], h, a0, a1);
        w = model_width(VECS[v], k);
        check(h == w, "R2 R3 R4 R5 R10 period width", h, w);
        check(a0 == 1, "R7 period strobe count", a0, 1);
        check(a1 == ((w != 0 && w < p) ? 1 : 0), "R8 pulse-end strobe count", a1,
              (w != 0 && w < p) ? 1 : 0);
      end
    end

    // R6: first period after start is empty; a mid-period write waits for the boundary
    a = '{2'd2, 1'b0, 16'h4000, 8'hFF, 1'b0};
    b = '{2'd2, 1'b0, 16'hC000, 8'hFF, 1'b0};
    @(negedge clk);
    run = 1'b0; mode = 2'd2; fine_en = 1'b0; irq_en = 2'b11;
    write_sample(a);
    run = 1'b1;
    measure_period(256, 1'b0, a, hi, e0, e1);
    check(hi == 0, "R6 first period empty", hi, 0);
    measure_period(256, 1'b1, b, hi, e0, e1);
    check(hi == 63, "R6 mid-period write holds width", hi, 63);
    measure_period(256, 1'b0, b, hi, e0, e1);
    check(hi == 191, "R6 new level at next boundary", hi, 191);

    // R7 R8: masked strobes stay silent while the pulse runs
    start_vec(a, 2'b00);
    measure_period(256, 1'b0, a, hi, e0, e1);
    check(e0 == 0 && e1 == 0, "R7 R8 strobes masked", e0 + e1, 0);
    check(hi == 63, "R10 pulse still produced", hi, 63);

    // R5: fine mode off in an 8+8 split ignores the fine field across periods
    start_vec('{2'd2, 1'b0, 16'h40FF, 8'hFF, 1'b0}, 2'b11);
    fin = 0;
    for (int k = 0; k < 3; k++) begin
      measure_period(256, 1'b0, a, hi, e0, e1);
      fin += hi;
    end
    check(fin == 3 * 64, "R5 fine off adds nothing", fin, 3 * 64);

    // R9: rate divisors with CLK_HZ = 480000
    measure_rate(3'd0, 60);
    measure_rate(3'd2, 21);
    measure_rate(3'd4, 10);
    measure_rate(3'd7, 10);

    // R1: dropping run clears the output
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check(pwm == 1'b0 && evt == 2'b00 && req == 1'b0, "R1 stop", int'({pwm, evt, req}), 0);

    finish_run();
  end
endmodule